// File: doc/BRIEF.md
# Register Context Save Sequencer

This block writes a snapshot of trapped state to memory on request. When the core issues a save command with a base address, the sequencer walks through a fixed layout of slots. It first emits a group of trap CSR words, then the integer registers x1 through x31 in ascending order. x0 is never stored. Every cycle it drives both register-file read ports at once and packs the two words into one double-width beat on a ready/valid write channel. CSR slots come straight from the CSR inputs, and no architectural register is involved. The x1 slot takes the value of the scratch CSR, because that is what x1 held when the trap was taken.

Each slot is one naturally aligned XLEN-bit word. The lower-numbered slot of a pair goes in the low half of a beat. When the slot count is odd, the last beat carries a zero pad in its high half. After the last beat is accepted, the block pulses done and, in the same cycle, pulses a clear of the trap critical-section flag. With the default of four CSR words there are 35 slots, which makes 18 beats. When memory never stalls, the save completes in under 20 cycles.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, busy, done, flag_clr and mem_valid are all low.
- R2: A start seen while idle is captured on a rising clock edge; busy and mem_valid are high from that edge on, and the first beat (slots 0 and 1) is presented.
- R3: Slot s for s < NCSR holds CSR word s, which is csr_in bits [s*XLEN +: XLEN]. Slot NCSR+k-1 holds integer register xk, for k = 1..31. x0 is never placed in any slot.
- R4: Beat j carries slot 2j in mem_data bits [XLEN-1:0] and slot 2j+1 in bits [2*XLEN-1:XLEN]. A slot index past the last register slot is a zero word.
- R5: The x1 slot carries the scratch input value, not the register-file read data.
- R6: The address of beat j is the captured base with its low log2(XLEN/8) bits cleared, plus j*2*XLEN/8. Every address is therefore XLEN-aligned.
- R7: While mem_valid is high and mem_ready is low, the beat index and the address hold. No beat is skipped or repeated, and exactly NBEAT beats (18 by default) are accepted.
- R8: done is high for exactly one cycle: the cycle after the edge that accepts the final beat. busy is low in that same cycle.
- R9: flag_clr pulses for one cycle together with done, and at no other time.
- R10: A start while busy is ignored. The base address and the beat sequence of the save in progress are unchanged.
- R11: With mem_ready held high, done is high in the cycle that begins NBEAT edges after the edge capturing start. This is 18 cycles by default, which is below 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Save command |
| base | input | AW | Context object byte address |
| csr_in | input | NCSR*XLEN | Trap CSR words, word i at bits [i*XLEN +: XLEN] |
| scratch | input | XLEN | Scratch CSR holding trap-time x1 |
| rf_raddr_a | output | 5 | Register read address for low slot |
| rf_rdata_a | input | XLEN | Read data for port a |
| rf_raddr_b | output | 5 | Register read address for high slot |
| rf_rdata_b | input | XLEN | Read data for port b |
| mem_valid | output | 1 | Beat valid |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | AW | Beat byte address |
| mem_data | output | 2*XLEN | Beat data, two slots |
| busy | output | 1 | Save in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_clr | output | 1 | Clear the trap critical-section flag |

## Verification
The assertions assume that the register file, the CSR inputs and scratch stay frozen for the whole save. The core is stalled while the save runs, so the data of a stalled beat depends only on the beat index. They also assume that mem_ready is a clean level sampled at the clock edge. The bench keeps to these assumptions by giving the register file a fixed function of the read address, and by changing mem_ready, start and base only just after a rising edge. It applies three ready patterns: always ready, alternating ready, and a stall on every third cycle. During one save it also sends a second start with a different base.

// File: rtl/ctx_save_seq.sv
module ctx_save_seq #(
  parameter int XLEN = 32,
  parameter int AW   = 32,
  parameter int NCSR = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          base,
  input  logic [NCSR*XLEN-1:0]   csr_in,
  input  logic [XLEN-1:0]        scratch,
  output logic [4:0]             rf_raddr_a,
  input  logic [XLEN-1:0]        rf_rdata_a,
  output logic [4:0]             rf_raddr_b,
  input  logic [XLEN-1:0]        rf_rdata_b,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic [AW-1:0]          mem_addr,
  output logic [2*XLEN-1:0]      mem_data,
  output logic                   busy,
  output logic                   done,
  output logic                   flag_clr
);
  localparam int NSLOT = NCSR + 31;
  localparam int NBEAT = (NSLOT + 1) / 2;
  localparam int BW    = $clog2(NBEAT + 1);
  localparam int AB    = $clog2(XLEN / 8);
  localparam int BEATB = 2 * XLEN / 8;

  logic [BW-1:0]   beat;
  logic [AW-1:0]   base_q;
  logic            busy_q, done_q;
  logic [XLEN-1:0] lo_w, hi_w;

  wire last = (beat == BW'(NBEAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      beat   <= '0;
      base_q <= '0;
    end else begin
      done_q <= busy_q && mem_ready && last;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          beat   <= '0;
          base_q <= {base[AW-1:AB], {AB{1'b0}}};
        end
      end else if (mem_ready) begin
        if (last) busy_q <= 1'b0;
        else      beat   <= beat + 1'b1;
      end
    end
  end

  function automatic logic [4:0] reg_of(input int s);
    if (s >= NCSR && s < NSLOT) return 5'(s - NCSR + 1);
    return 5'd0;
  endfunction

  function automatic logic [XLEN-1:0] slot_word(input int s, input logic [XLEN-1:0] rd,
                                                input logic [NCSR*XLEN-1:0] cw,
                                                input logic [XLEN-1:0] scr);
    logic [XLEN-1:0] w;
    w = '0;
    for (int i = 0; i < NCSR; i++)
      if (s == i) w = cw[i*XLEN +: XLEN];
    if (s == NCSR)                 w = scr;
    else if (s > NCSR && s < NSLOT) w = rd;
    return w;
  endfunction

  always_comb begin
    int slo;
    slo        = 2 * int'(beat);
    rf_raddr_a = reg_of(slo);
    rf_raddr_b = reg_of(slo + 1);
    lo_w       = slot_word(slo, rf_rdata_a, csr_in, scratch);
    hi_w       = slot_word(slo + 1, rf_rdata_b, csr_in, scratch);
  end

  assign mem_valid = busy_q;
  assign mem_data  = {hi_w, lo_w};
  assign mem_addr  = base_q + AW'(int'(beat) * BEATB);
  assign busy      = busy_q;
  assign done      = done_q;
  assign flag_clr  = done_q;

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && busy |=> !busy || mem_addr == $past(mem_addr) + AW'(BEATB));
  assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[AB-1:0] == '0);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(mem_valid && mem_ready));
  assert_flag_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> $fell(busy));
  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !mem_ready |=> busy && $stable(mem_addr));
  assert_no_x0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && int'(beat) * 2 >= NCSR |-> rf_raddr_a != 5'd0);
endmodule

// File: tb/sim_ctx_save_seq.sv
`timescale 1ns/1ps
module sim_ctx_save_seq;
  localparam int XLEN = 32, AW = 32, NCSR = 4;
  localparam int NSLOT = NCSR + 31, NBEAT = (NSLOT + 1) / 2;

  logic clk = 0, rst_n = 0, start = 0, mem_ready = 0;
  logic [AW-1:0] base = '0;
  logic [NCSR*XLEN-1:0] csr_in;
  logic [XLEN-1:0] scratch = 32'hDEAD_0001;
  logic [4:0] rf_raddr_a, rf_raddr_b;
  logic [XLEN-1:0] rf_rdata_a, rf_rdata_b;
  logic mem_valid, busy, done, flag_clr;
  logic [AW-1:0] mem_addr;
  logic [2*XLEN-1:0] mem_data;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [XLEN-1:0] rfval(input logic [4:0] i);
    return {16'h5A5A, 11'd0, i};
  endfunction
  assign rf_rdata_a = rfval(rf_raddr_a);
  assign rf_rdata_b = rfval(rf_raddr_b);

  initial for (int i = 0; i < NCSR; i++) csr_in[i*XLEN +: XLEN] = 32'hC500_0000 + i;

  ctx_save_seq #(.XLEN(XLEN), .AW(AW), .NCSR(NCSR)) u0 (
    .clk, .rst_n, .start, .base, .csr_in, .scratch,
    .rf_raddr_a, .rf_rdata_a, .rf_raddr_b, .rf_rdata_b,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .busy, .done, .flag_clr);

  function automatic logic [XLEN-1:0] exp_slot(input int s);
    if (s < NCSR) return 32'hC500_0000 + s;
    if (s == NCSR) return 32'hDEAD_0001;
    if (s < NSLOT) return rfval(5'(s - NCSR + 1));
    return '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 flag_clr", flag_clr, 0);
    chk("R1 mem_valid", mem_valid, 0);
  endtask

  // mode 0: always ready; 1: alternating; 2: stall every third; 3: always ready + start while busy
  task automatic run_save(input logic [AW-1:0] b, input int mode);
    int n = 0, i = 0, flags = 0;
    logic [AW-1:0] ab;
    bit fin = 0;
    ab = {b[AW-1:2], 2'b00};
    @(posedge clk); #1 start = 1; base = b;
    while (!fin && i < 200) begin
      @(posedge clk); i++;
      #1;
      start = (mode == 3 && i == 5);
      if (start) base = 32'h7777_0000;
      mem_ready = (mode == 1) ? (i % 2 == 0) : (mode == 2) ? (i % 3 != 0) : 1'b1;
      @(negedge clk);
      if (i == 1) begin
        chk("R2 busy", busy, 1);
        chk("R2 valid", mem_valid, 1);
      end
      if (flag_clr) flags++;
      if (mem_valid && mem_ready) begin
        chk("R3 R4 R5 data", mem_data, {exp_slot(2*n+1), exp_slot(2*n)});
        chk("R6 R7 R10 addr", mem_addr, ab + AW'(8*n));
        n++;
      end
      if (done) begin
        fin = 1;
        chk("R7 beat count", n, NBEAT);
        chk("R8 busy low at done", busy, 0);
        chk("R9 flag_clr with done", flag_clr, 1);
        if (mode == 0 || mode == 3) chk("R11 latency", i - 1, NBEAT);
      end
    end
    chk("R8 done seen", fin, 1);
    mem_ready = 0;
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R9 flag_clr one cycle", flag_clr, 0);
    chk("R9 flag_clr count", flags, 1);
    chk("R10 idle after", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    rst_n = 1;
    run_save(32'h1000_0013, 0);
    run_save(32'h2000_0040, 1);
    run_save(32'h3000_0104, 2);
    run_save(32'h4000_0000, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule